// File: doc/BRIEF.md
# RTC Alarm and Interrupt Controller

This block sits beside a calendar counter and turns its outputs into a single interrupt request. It holds six alarm bytes (seconds, minutes, hours, day, month, year) in BCD. On each calendar update tick it compares them with the six current time fields, and raises a sticky alarm flag when all six are equal. It also latches the calendar's rollover pulses into sticky event flags, and only the flag for the periodic rate that software has selected is latched. A power-up flag records that the block has come out of a cold reset.

Software reaches the block through a byte-wide register port. Writes are strobed and take effect at the next clock edge. Reads are combinational from the address. Status flags are cleared by writing 1 to their bit, and writing 0 leaves them alone. The interrupt output combines an enabled alarm flag with an enabled periodic flag. It stays high until software clears the flag that caused it.

The alarm flag is a two-state machine. ALM_WAIT moves to ALM_HIT on a tick with a full match. ALM_HIT moves back to ALM_WAIT on a write-1 clear of bit 6, except when a tick with a full match arrives in the same cycle; in that case it stays in ALM_HIT. The power-up flag is a second two-state machine. Reset enters PUP_COLD. PUP_COLD moves to PUP_WARM on a write-1 clear of bit 7. PUP_WARM is left only by reset.

Top module: `rtcai_ctrl`

## Requirements
- R1: After reset the alarm bytes and the enable register read 0x00, the status register reads 0x80 with bit 1 equal to `cal_run`, and `irq_out` is low.
- R2: The alarm bytes are read and written as full bytes at addresses 0x07 (seconds), 0x08 (minutes), 0x09 (hours), 0x0A (day), 0x0B (month) and 0x0C (year). The enable register at 0x0F keeps bits 3:0, and bits 7:4 read 0. Any other address reads 0x00.
- R3: Status bit 6 (alarm) becomes 1 at the clock edge where `cal_tick` is high and all six current fields equal the six alarm bytes. It does not set without the tick, and it does not set when any one field differs.
- R4: Status bits 6 and 7 stay set until software writes 1 to that bit at address 0x0E. Writing 0 to them has no effect.
- R5: If an alarm match and a write-1 clear of bit 6 happen in the same cycle, the alarm flag stays set.
- R6: Enable bits 1:0 select the periodic rate: 0 = second, 1 = minute, 2 = hour, 3 = day. Only the rollover pulse for the selected rate sets its status flag, at bit 2 + rate. Pulses for the other rates are ignored.
- R7: The periodic flags in status bits 5:2 are sticky and are cleared by writing 1 to them.
- R8: Status bit 1 follows `cal_run` and cannot be written. Status bit 0 always reads 0.
- R9: `irq_out` is high exactly when (status bit 6 AND enable bit 3) or (the flag at bit 2 + rate AND enable bit 2).
- R10: Status bit 7 (power-up) is 1 after every reset. Once cleared, it stays 0 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| cal_run | input | 1 | Calendar running indication |
| cal_tick | input | 1 | One-cycle pulse when the time fields have updated |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_day | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| cur_year | input | 8 | Current year, BCD |
| roll_sec | input | 1 | Seconds rollover pulse |
| roll_min | input | 1 | Minutes rollover pulse |
| roll_hour | input | 1 | Hours rollover pulse |
| roll_day | input | 1 | Day rollover pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_out | output | 1 | Merged interrupt request |

## Verification
The assertions check the flag behaviour on every cycle. A tick with a match always leaves the alarm flag set. The alarm flag never rises without a match and never drops without a clear. A periodic flag only rises after its own selected pulse. The power-up flag never comes back without a reset. An enabled alarm flag always drives the interrupt, and the interrupt is quiet when no flag is set. The scenarios in the bench are needed for the rest: the register address map and the read-only bits, the rejection of a near-miss match, the masking of the interrupt by the enable bits, and the clear-versus-set race.

// File: rtl/rtcai_pkg.sv
package rtcai_pkg;
    localparam int DW     = 8;
    localparam int AW     = 5;
    localparam int NFIELD = 6;
    localparam int NRATE  = 4;
    localparam int RW     = $clog2(NRATE);

    localparam logic [AW-1:0] ADR_ALM_BASE = 5'h07;
    localparam logic [AW-1:0] ADR_STATUS   = 5'h0E;
    localparam logic [AW-1:0] ADR_INTEN    = 5'h0F;

    localparam int ST_RUN  = 1;
    localparam int ST_EVT0 = 2;
    localparam int ST_ALM  = 6;
    localparam int ST_PUP  = 7;
    localparam int IE_TMR  = 2;
    localparam int IE_ALM  = 3;

    typedef enum logic {ALM_WAIT, ALM_HIT}   alm_state_t;
    typedef enum logic {PUP_COLD, PUP_WARM}  pup_state_t;
endpackage

// File: rtl/rtcai_regs.sv
module rtcai_regs
    import rtcai_pkg::*;
#(
    parameter int P_DW     = DW,
    parameter int P_AW     = AW,
    parameter int P_NFIELD = NFIELD,
    parameter int P_RW     = RW
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [P_AW-1:0]                   addr,
    input  logic [P_DW-1:0]                   wdata,
    output logic [P_NFIELD-1:0][P_DW-1:0]     alm_regs,
    output logic [P_RW-1:0]                   ie_rate,
    output logic                              ie_tmr,
    output logic                              ie_alm
);
    genvar g;
    generate
        for (g = 0; g < P_NFIELD; g++) begin : g_alm
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    alm_regs[g] <= '0;
                else if (wr_en && addr == ADR_ALM_BASE + P_AW'(g))
                    alm_regs[g] <= wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_rate <= '0;
            ie_tmr  <= 1'b0;
            ie_alm  <= 1'b0;
        end else if (wr_en && addr == ADR_INTEN) begin
            ie_rate <= wdata[P_RW-1:0];
            ie_tmr  <= wdata[IE_TMR];
            ie_alm  <= wdata[IE_ALM];
        end
    end
endmodule

// File: rtl/rtcai_alarm.sv
module rtcai_alarm
    import rtcai_pkg::*;
#(
    parameter int P_DW     = DW,
    parameter int P_NFIELD = NFIELD
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic [P_NFIELD-1:0][P_DW-1:0] cur_time,
    input  logic [P_NFIELD-1:0][P_DW-1:0] alm_regs,
    input  logic                          clr_req,
    output logic                          alm_flag
);
    alm_state_t state_q, state_d;
    logic       hit;

    assign hit = tick && (cur_time == alm_regs);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ALM_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_WAIT: if (hit)              state_d = ALM_HIT;
            ALM_HIT:  if (clr_req && !hit)  state_d = ALM_WAIT;
            default:                        state_d = ALM_WAIT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ALM_HIT: alm_flag = 1'b1;
            default: alm_flag = 1'b0;
        endcase
    end

    AST_ALARM_SETS:   assert property (@(posedge clk) disable iff (!rst_n) hit |=> alm_flag);                  // R3
    AST_ALARM_NOSPUR: assert property (@(posedge clk) disable iff (!rst_n) (!alm_flag && !hit) |=> !alm_flag); // R3
    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (alm_flag && !clr_req) |=> alm_flag); // R4
    AST_ALARM_RACE:   assert property (@(posedge clk) disable iff (!rst_n) (hit && clr_req) |=> alm_flag);     // R5
endmodule

// File: rtl/rtcai_status.sv
module rtcai_status
    import rtcai_pkg::*;
#(
    parameter int P_NRATE = NRATE,
    parameter int P_RW    = RW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [P_NRATE-1:0] roll,
    input  logic [P_RW-1:0]    rate,
    input  logic [P_NRATE-1:0] clr_evt,
    input  logic               clr_pup,
    output logic [P_NRATE-1:0] evt_flags,
    output logic               pup_flag
);
    pup_state_t pup_q, pup_d;

    genvar g;
    generate
        for (g = 0; g < P_NRATE; g++) begin : g_evt
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    evt_flags[g] <= 1'b0;
                else if (roll[g] && rate == P_RW'(g))
                    evt_flags[g] <= 1'b1;
                else if (clr_evt[g])
                    evt_flags[g] <= 1'b0;
            end

            AST_EVT_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(evt_flags[g]) |-> $past(roll[g] && rate == P_RW'(g))); // R6
            AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (evt_flags[g] && !clr_evt[g]) |=> evt_flags[g]); // R7
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pup_q <= PUP_COLD;
        else        pup_q <= pup_d;
    end

    always_comb begin
        pup_d = pup_q;
        unique case (pup_q)
            PUP_COLD: if (clr_pup) pup_d = PUP_WARM;
            PUP_WARM:              pup_d = PUP_WARM;
            default:               pup_d = PUP_COLD;
        endcase
    end

    always_comb begin
        unique case (pup_q)
            PUP_COLD: pup_flag = 1'b1;
            default:  pup_flag = 1'b0;
        endcase
    end

    AST_PUP_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n) !pup_flag |=> !pup_flag); // R10
endmodule

// File: rtl/rtcai_ctrl.sv
module rtcai_ctrl
    import rtcai_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cal_run,
    input  logic          cal_tick,
    input  logic [DW-1:0] cur_sec,
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hour,
    input  logic [DW-1:0] cur_day,
    input  logic [DW-1:0] cur_mon,
    input  logic [DW-1:0] cur_year,
    input  logic          roll_sec,
    input  logic          roll_min,
    input  logic          roll_hour,
    input  logic          roll_day,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_out
);
    logic [NFIELD-1:0][DW-1:0] cur_time;
    logic [NFIELD-1:0][DW-1:0] alm_regs;
    logic [RW-1:0]             ie_rate;
    logic                      ie_tmr, ie_alm;
    logic                      st_wr;
    logic                      alm_flag, pup_flag;
    logic [NRATE-1:0]          evt_flags;
    logic [NRATE-1:0]          roll;
    logic [DW-1:0]             status;
    logic                      per_flag;

    assign cur_time = {cur_year, cur_mon, cur_day, cur_hour, cur_min, cur_sec};
    assign roll     = {roll_day, roll_hour, roll_min, roll_sec};
    assign st_wr    = reg_wr && (reg_addr == ADR_STATUS);

    rtcai_regs #(.P_DW(DW), .P_AW(AW), .P_NFIELD(NFIELD), .P_RW(RW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .alm_regs (alm_regs),
        .ie_rate  (ie_rate),
        .ie_tmr   (ie_tmr),
        .ie_alm   (ie_alm)
    );

    rtcai_alarm #(.P_DW(DW), .P_NFIELD(NFIELD)) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (cal_tick),
        .cur_time (cur_time),
        .alm_regs (alm_regs),
        .clr_req  (st_wr && reg_wdata[ST_ALM]),
        .alm_flag (alm_flag)
    );

    rtcai_status #(.P_NRATE(NRATE), .P_RW(RW)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .roll      (roll),
        .rate      (ie_rate),
        .clr_evt   (st_wr ? reg_wdata[ST_EVT0 +: NRATE] : '0),
        .clr_pup   (st_wr && reg_wdata[ST_PUP]),
        .evt_flags (evt_flags),
        .pup_flag  (pup_flag)
    );

    always_comb begin
        status                      = '0;
        status[ST_RUN]              = cal_run;
        status[ST_EVT0 +: NRATE]    = evt_flags;
        status[ST_ALM]              = alm_flag;
        status[ST_PUP]              = pup_flag;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NFIELD; i++)
            if (reg_addr == ADR_ALM_BASE + AW'(i)) reg_rdata = alm_regs[i];
        if (reg_addr == ADR_STATUS) reg_rdata = status;
        if (reg_addr == ADR_INTEN)  reg_rdata = DW'({ie_alm, ie_tmr, ie_rate});
    end

    assign per_flag = evt_flags[ie_rate];
    assign irq_out  = (alm_flag && ie_alm) || (per_flag && ie_tmr);

    AST_IRQ_ALARM: assert property (@(posedge clk) disable iff (!rst_n) (alm_flag && ie_alm) |-> irq_out);       // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!alm_flag && evt_flags == '0) |-> !irq_out); // R9
endmodule

// File: tb/test_rtcai_ctrl.sv
module test_rtcai_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_run = 1'b1, cal_tick = 1'b0;
    logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_day = 0, cur_mon = 0, cur_year = 0;
    logic       roll_sec = 0, roll_min = 0, roll_hour = 0, roll_day = 0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_out;
    int         n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    rtcai_ctrl i_rtcai_ctrl (
        .clk(clk), .rst_n(rst_n), .cal_run(cal_run), .cal_tick(cal_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_day(cur_day), .cur_mon(cur_mon), .cur_year(cur_year),
        .roll_sec(roll_sec), .roll_min(roll_min), .roll_hour(roll_hour), .roll_day(roll_day),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic tick_once();
        @(negedge clk); cal_tick = 1'b1;
        @(negedge clk); cal_tick = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, d, mo, y);
        cur_sec = s; cur_min = mi; cur_hour = h; cur_day = d; cur_mon = mo; cur_year = y;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int i = 7; i <= 12; i++) begin
            rd(5'(i), v); chk("R1 alarm byte reset", v, 8'h00);
        end
        rd(5'h0F, v); chk("R1 enable reset", v, 8'h00);
        rd(5'h0E, v); chk("R1 status reset", v, 8'h82);
        chk("R1 irq reset", {7'd0, irq_out}, 8'h00);
    endtask

    task automatic t_map();
        logic [7:0] v;
        for (int i = 0; i < 6; i++) wr(5'(7 + i), 8'h11 * 8'(i + 1));
        for (int i = 0; i < 6; i++) begin
            rd(5'(7 + i), v); chk("R2 alarm byte readback", v, 8'h11 * 8'(i + 1));
        end
        wr(5'h0F, 8'hF6);
        rd(5'h0F, v); chk("R2 enable keeps low nibble", v, 8'h06);
        wr(5'h0F, 8'h00);
        rd(5'h0D, v); chk("R2 unmapped reads zero", v, 8'h00);
        rd(5'h10, v); chk("R2 unmapped reads zero", v, 8'h00);
    endtask

    task automatic t_runbit();
        logic [7:0] v;
        cal_run = 1'b0;
        rd(5'h0E, v); chk("R8 run bit low", v, 8'h80);
        wr(5'h0E, 8'h03);
        rd(5'h0E, v); chk("R8 run and bit0 unwritable", v, 8'h80);
        cal_run = 1'b1;
        rd(5'h0E, v); chk("R8 run bit follows", v, 8'h82);
    endtask

    task automatic t_powerup();
        logic [7:0] v;
        wr(5'h0E, 8'h00);
        rd(5'h0E, v); chk("R4 write 0 keeps power-up", v, 8'h82);
        wr(5'h0E, 8'h80);
        rd(5'h0E, v); chk("R10 power-up cleared", v, 8'h02);
        repeat (3) @(negedge clk);
        rd(5'h0E, v); chk("R10 power-up stays clear", v, 8'h02);
    endtask

    task automatic t_alarm();
        logic [7:0] v;
        wr(5'h07, 8'h59); wr(5'h08, 8'h30); wr(5'h09, 8'h23);
        wr(5'h0A, 8'h31); wr(5'h0B, 8'h12); wr(5'h0C, 8'h99);
        set_time(8'h59, 8'h30, 8'h23, 8'h31, 8'h12, 8'h99);
        repeat (2) @(negedge clk);
        rd(5'h0E, v); chk("R3 no set without tick", v & 8'h40, 8'h00);
        set_time(8'h59, 8'h30, 8'h23, 8'h31, 8'h12, 8'h98);
        tick_once();
        rd(5'h0E, v); chk("R3 year differs no set", v & 8'h40, 8'h00);
        set_time(8'h58, 8'h30, 8'h23, 8'h31, 8'h12, 8'h99);
        tick_once();
        rd(5'h0E, v); chk("R3 seconds differ no set", v & 8'h40, 8'h00);
        set_time(8'h59, 8'h30, 8'h23, 8'h31, 8'h12, 8'h99);
        tick_once();
        rd(5'h0E, v); chk("R3 match sets alarm", v & 8'h40, 8'h40);
        chk("R9 irq masked without enable", {7'd0, irq_out}, 8'h00);
        wr(5'h0F, 8'h08);
        chk("R9 irq with alarm enable", {7'd0, irq_out}, 8'h01);
        set_time(8'h00, 8'h31, 8'h23, 8'h31, 8'h12, 8'h99);
        tick_once(); tick_once();
        rd(5'h0E, v); chk("R4 alarm sticky", v & 8'h40, 8'h40);
        chk("R9 irq held", {7'd0, irq_out}, 8'h01);
        wr(5'h0E, 8'h3C);
        rd(5'h0E, v); chk("R4 other bits do not clear alarm", v & 8'h40, 8'h40);
        wr(5'h0E, 8'h40);
        rd(5'h0E, v); chk("R4 alarm cleared", v & 8'h40, 8'h00);
        chk("R9 irq drops", {7'd0, irq_out}, 8'h00);
    endtask

    task automatic t_race();
        logic [7:0] v;
        set_time(8'h59, 8'h30, 8'h23, 8'h31, 8'h12, 8'h99);
        @(negedge clk);
        reg_addr = 5'h0E; reg_wdata = 8'h40; reg_wr = 1'b1; cal_tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; cal_tick = 1'b0;
        rd(5'h0E, v); chk("R5 set wins over clear", v & 8'h40, 8'h40);
        wr(5'h0E, 8'h40);
        rd(5'h0E, v); chk("R5 later clear works", v & 8'h40, 8'h00);
        wr(5'h0F, 8'h00);
    endtask

    task automatic t_periodic();
        logic [7:0] v;
        wr(5'h0F, 8'h05);
        @(negedge clk); roll_sec = 1'b1; roll_hour = 1'b1; roll_day = 1'b1;
        @(negedge clk); roll_sec = 1'b0; roll_hour = 1'b0; roll_day = 1'b0;
        rd(5'h0E, v); chk("R6 other rates ignored", v & 8'h3C, 8'h00);
        chk("R9 no irq from ignored pulses", {7'd0, irq_out}, 8'h00);
        @(negedge clk); roll_min = 1'b1;
        @(negedge clk); roll_min = 1'b0;
        rd(5'h0E, v); chk("R6 minute flag set", v & 8'h3C, 8'h08);
        chk("R9 timer irq", {7'd0, irq_out}, 8'h01);
        wr(5'h0F, 8'h01);
        chk("R9 timer enable masks irq", {7'd0, irq_out}, 8'h00);
        wr(5'h0E, 8'h04);
        rd(5'h0E, v); chk("R7 wrong bit leaves flag", v & 8'h3C, 8'h08);
        wr(5'h0E, 8'h08);
        rd(5'h0E, v); chk("R7 minute flag cleared", v & 8'h3C, 8'h00);
        wr(5'h0F, 8'h07);
        @(negedge clk); roll_day = 1'b1;
        @(negedge clk); roll_day = 1'b0;
        rd(5'h0E, v); chk("R6 day flag at bit 5", v & 8'h3C, 8'h20);
        chk("R9 irq on day", {7'd0, irq_out}, 8'h01);
        wr(5'h0E, 8'h20);
        chk("R7 irq drops after clear", {7'd0, irq_out}, 8'h00);
        wr(5'h0F, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_runbit();
        t_powerup();
        t_alarm();
        t_race();
        t_periodic();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule